// File: doc/BRIEF.md
# Virtual Module Stub Router

The router takes one event's worth of detector position measurements (stubs) and spreads them over a set of fine bins, so that later pairing logic only has to look at small, pre-sorted groups. A start pulse opens each event. The router then pulls stubs from three input memories, one stub per clock, taking the memories in turn. Each stub is written twice. The first copy goes, unchanged, into a shared full-stub memory at the next free slot. The second copy is a compact record of a few fine position bits and a 6-bit pointer to that slot, and it goes into exactly one bin memory. The bin is picked from the coarse azimuth and z bits of the stub.

Every memory address carries the event number in its top bits, so several events can sit in the same memories side by side. The widths of the coarse and fine fields are parameters, and these widths set the bin boundaries. A second parameter picks the bit layout of the stub, for inner or outer barrel layers. Each bin holds a fixed number of entries per event. Stubs that arrive after a bin is full are dropped, and the router counts them. Consecutive start pulses must be at least BUDGET+3 cycles apart.

Top module: `vm_stub_router`

## Requirements
- R1: A start pulse latches the event number and the three per-input stub counts, and it restarts all per-event state. The first read address is presented in the cycle after the start cycle. The first full-stub write appears two cycles after that.
- R2: One stub is read per cycle. The reader serves the inputs round-robin in the order 0, 1, 2 and skips any input that has no stubs left. The pointer starts at input 0 on each event and moves to the input after the one just served.
- R3: Reading stops as soon as all inputs are exhausted or BUDGET stubs (default 48) have been read, whichever happens first.
- R4: The k-th stub read in an event is written at full 36-bit width to the full-stub memory at address {event, k[5:0]}.
- R5: With the inner layout, the bin number is {stub[25], stub[13:12]}, which gives 8 bins. Exactly one bin write, or one drop, follows each stub read.
- R6: With the outer layout selected by parameter, the bin number is {stub[21], stub[13:12]}.
- R7: A bin entry is 11 bits wide: {k[5:0], zfine[1:0], stub[11:9]}. Here zfine is stub[24:23] for the inner layout and stub[20:19] for the outer layout. The entry is written at bin address {event, slot}, and slot counts from 0 within each bin and event.
- R8: Each bin accepts at most 8 entries per event, and its slot counter clears on start. Each further stub for a full bin is not written. Instead it increments drop_cnt_o, which clears on start.
- R9: While reset is asserted and after it is released, the router makes no writes and drop_cnt_o reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start of event, one-cycle pulse |
| evt_i | input | 2 | Event number, sampled on start |
| in_cnt_i | input | 18 | Stub count per input, 6 bits each, input 0 in the low bits |
| in_raddr_o | output | 21 | Read address per input: {event, 5-bit position} |
| in_rdata_i | input | 108 | Read data per input, valid one cycle after the address |
| all_we_o | output | 1 | Full-stub memory write enable |
| all_waddr_o | output | 8 | Full-stub memory address {event, index} |
| all_wdata_o | output | 36 | Full-stub memory data |
| vm_we_o | output | 8 | Write enable, one bit per bin memory |
| vm_waddr_o | output | 5 | Bin memory address {event, slot} |
| vm_wdata_o | output | 11 | Bin entry |
| drop_cnt_o | output | 7 | Stubs dropped on full bins in the current event |

## Verification
Hashed stubs spread over all bins. With these stubs, any fault in index assignment, in full-stub data or in field extraction shows up as a wrong value at a known address. Event shapes with empty inputs and uneven counts tell apart a correct round-robin skip from a fixed-priority or non-skipping scan. Events larger than the budget check the stop rule separately from the exhaustion rule. An event forced into a single bin is used to check the capacity limit and the drop count. The same stimulus is driven into an outer-layout instance, which separates the two field layouts.

// File: rtl/vmr_pkg.sv
package vmr_pkg;
  typedef enum logic {LAYOUT_INNER = 1'b0, LAYOUT_OUTER = 1'b1} vmr_layout_e;

  // Stub field positions (MSB of each field)
  localparam int PHI_MSB      = 13;
  localparam int Z_MSB_INNER  = 25;
  localparam int Z_MSB_OUTER  = 21;
endpackage

// File: rtl/vmr_reader.sv
module vmr_reader #(
  parameter int N_IN   = 3,
  parameter int IN_AW  = 5,
  parameter int EVT_W  = 2,
  parameter int IDX_W  = 6,
  parameter int BUDGET = 48,
  localparam int CNT_W = IN_AW + 1,
  localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int ISS_W = $clog2(BUDGET + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [EVT_W-1:0]              evt_i,
  input  logic [N_IN*CNT_W-1:0]         cnt_i,
  output logic [N_IN*(EVT_W+IN_AW)-1:0] raddr_o,
  output logic                          iss_vld_o,
  output logic [SEL_W-1:0]              iss_sel_o,
  output logic [IDX_W-1:0]              iss_idx_o,
  output logic [EVT_W-1:0]              iss_evt_o
);
  logic             active_q, active_d;
  logic [EVT_W-1:0] evt_q, evt_d;
  logic [CNT_W-1:0] ptr_q [N_IN];
  logic [CNT_W-1:0] ptr_d [N_IN];
  logic [CNT_W-1:0] cnt_q [N_IN];
  logic [CNT_W-1:0] cnt_d [N_IN];
  logic [SEL_W-1:0] rr_q, rr_d, pick;
  logic [ISS_W-1:0] issued_q, issued_d;
  logic [N_IN-1:0]  has;
  logic             found, go;

  always_comb begin
    for (int i = 0; i < N_IN; i++) has[i] = ptr_q[i] < cnt_q[i];
    found = 1'b0;
    pick  = '0;
    for (int k = 0; k < N_IN; k++) begin
      if (!found && has[(int'(rr_q) + k) % N_IN]) begin
        found = 1'b1;
        pick  = SEL_W'((int'(rr_q) + k) % N_IN);
      end
    end
    go = active_q && !start_i && found && (issued_q < ISS_W'(BUDGET));
  end

  always_comb begin
    active_d = active_q;
    evt_d    = evt_q;
    rr_d     = rr_q;
    issued_d = issued_q;
    for (int i = 0; i < N_IN; i++) begin
      ptr_d[i] = ptr_q[i];
      cnt_d[i] = cnt_q[i];
    end
    if (start_i) begin
      active_d = 1'b1;
      evt_d    = evt_i;
      rr_d     = '0;
      issued_d = '0;
      for (int i = 0; i < N_IN; i++) begin
        ptr_d[i] = '0;
        cnt_d[i] = cnt_i[i*CNT_W +: CNT_W];
      end
    end else if (go) begin
      ptr_d[pick] = ptr_q[pick] + 1'b1;
      issued_d    = issued_q + 1'b1;
      rr_d        = (pick == SEL_W'(N_IN - 1)) ? '0 : pick + SEL_W'(1);
    end else if (active_q) begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      evt_q    <= '0;
      rr_q     <= '0;
      issued_q <= '0;
      for (int i = 0; i < N_IN; i++) begin
        ptr_q[i] <= '0;
        cnt_q[i] <= '0;
      end
    end else begin
      active_q <= active_d;
      evt_q    <= evt_d;
      rr_q     <= rr_d;
      issued_q <= issued_d;
      for (int i = 0; i < N_IN; i++) begin
        ptr_q[i] <= ptr_d[i];
        cnt_q[i] <= cnt_d[i];
      end
    end
  end

  // Issue stage: memory data arrives together with these registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_vld_o <= 1'b0;
      iss_sel_o <= '0;
      iss_idx_o <= '0;
      iss_evt_o <= '0;
    end else begin
      iss_vld_o <= go;
      if (go) begin
        iss_sel_o <= pick;
        iss_idx_o <= IDX_W'(issued_q);
        iss_evt_o <= evt_q;
      end
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_addr
    assign raddr_o[i*(EVT_W+IN_AW) +: (EVT_W+IN_AW)] = {evt_q, ptr_q[i][IN_AW-1:0]};
  end

  // R3
  budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issued_q <= ISS_W'(BUDGET));

  // R1
  start_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (active_q && issued_q == '0 && !iss_vld_o));
endmodule

// File: rtl/vmr_binner.sv
module vmr_binner
  import vmr_pkg::*;
#(
  parameter vmr_layout_e LAYOUT = LAYOUT_INNER,
  parameter int STUB_W = 36,
  parameter int IDX_W  = 6,
  parameter int PHI_CB = 2,
  parameter int Z_CB   = 1,
  parameter int PHI_FB = 3,
  parameter int Z_FB   = 2,
  localparam int BIN_W = PHI_CB + Z_CB,
  localparam int ENT_W = IDX_W + Z_FB + PHI_FB
) (
  input  logic [STUB_W-1:0] stub_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [BIN_W-1:0]  bin_o,
  output logic [ENT_W-1:0]  entry_o
);
  logic [PHI_CB-1:0] phi_c;
  logic [PHI_FB-1:0] phi_f;
  logic [Z_CB-1:0]   z_c;
  logic [Z_FB-1:0]   z_f;
  logic              unused_stub;

  assign phi_c = stub_i[PHI_MSB -: PHI_CB];
  assign phi_f = stub_i[PHI_MSB-PHI_CB -: PHI_FB];

  if (LAYOUT == LAYOUT_INNER) begin : g_inner
    assign z_c = stub_i[Z_MSB_INNER -: Z_CB];
    assign z_f = stub_i[Z_MSB_INNER-Z_CB -: Z_FB];
  end else begin : g_outer
    assign z_c = stub_i[Z_MSB_OUTER -: Z_CB];
    assign z_f = stub_i[Z_MSB_OUTER-Z_CB -: Z_FB];
  end

  assign unused_stub = ^stub_i;
  assign bin_o   = {z_c, phi_c};
  assign entry_o = {idx_i, z_f, phi_f};
endmodule

// File: rtl/vmr_bin_writer.sv
module vmr_bin_writer #(
  parameter int STUB_W = 36,
  parameter int EVT_W  = 2,
  parameter int IDX_W  = 6,
  parameter int BIN_W  = 3,
  parameter int ENT_W  = 11,
  parameter int VM_AW  = 3,
  localparam int N_VM  = 2 ** BIN_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic                   vld_i,
  input  logic [EVT_W-1:0]       evt_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [STUB_W-1:0]      stub_i,
  input  logic [BIN_W-1:0]       bin_i,
  input  logic [ENT_W-1:0]       entry_i,
  output logic                   all_we_o,
  output logic [EVT_W+IDX_W-1:0] all_waddr_o,
  output logic [STUB_W-1:0]      all_wdata_o,
  output logic [N_VM-1:0]        vm_we_o,
  output logic [EVT_W+VM_AW-1:0] vm_waddr_o,
  output logic [ENT_W-1:0]       vm_wdata_o,
  output logic [IDX_W:0]         drop_cnt_o
);
  logic [N_VM-1:0][VM_AW:0] fill_q, fill_d;
  logic [N_VM-1:0]          vm_we_d;
  logic [IDX_W:0]           drop_d;
  logic                     full;

  assign full = fill_q[bin_i][VM_AW];

  always_comb begin
    for (int b = 0; b < N_VM; b++) begin
      vm_we_d[b] = vld_i && !full && (bin_i == BIN_W'(b));
      if (start_i)        fill_d[b] = '0;
      else if (vm_we_d[b]) fill_d[b] = fill_q[b] + 1'b1;
      else                fill_d[b] = fill_q[b];
    end
    if (start_i)            drop_d = '0;
    else if (vld_i && full) drop_d = drop_cnt_o + 1'b1;
    else                    drop_d = drop_cnt_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q      <= '0;
      drop_cnt_o  <= '0;
      all_we_o    <= 1'b0;
      vm_we_o     <= '0;
      all_waddr_o <= '0;
      all_wdata_o <= '0;
      vm_waddr_o  <= '0;
      vm_wdata_o  <= '0;
    end else begin
      fill_q     <= fill_d;
      drop_cnt_o <= drop_d;
      all_we_o   <= vld_i;
      vm_we_o    <= vm_we_d;
      if (vld_i) begin
        all_waddr_o <= {evt_i, idx_i};
        all_wdata_o <= stub_i;
        vm_waddr_o  <= {evt_i, fill_q[bin_i][VM_AW-1:0]};
        vm_wdata_o  <= entry_i;
      end
    end
  end

  // R5
  onehot_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vm_we_o));

  // R4
  all_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |=> all_we_o);

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (all_we_o && $past(all_we_o)) |->
      (all_waddr_o[IDX_W-1:0] == $past(all_waddr_o[IDX_W-1:0]) + 1'b1));

  for (genvar g = 0; g < N_VM; g++) begin : g_cap
    // R8
    fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q[g] <= (VM_AW+1)'(2 ** VM_AW));
  end
endmodule

// File: rtl/vm_stub_router.sv
module vm_stub_router
  import vmr_pkg::*;
#(
  parameter vmr_layout_e LAYOUT = LAYOUT_INNER,
  parameter int N_IN   = 3,
  parameter int STUB_W = 36,
  parameter int IN_AW  = 5,
  parameter int EVT_W  = 2,
  parameter int IDX_W  = 6,
  parameter int BUDGET = 48,
  parameter int PHI_CB = 2,
  parameter int Z_CB   = 1,
  parameter int PHI_FB = 3,
  parameter int Z_FB   = 2,
  parameter int VM_AW  = 3,
  localparam int CNT_W = IN_AW + 1,
  localparam int BIN_W = PHI_CB + Z_CB,
  localparam int N_VM  = 2 ** BIN_W,
  localparam int ENT_W = IDX_W + Z_FB + PHI_FB,
  localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [EVT_W-1:0]              evt_i,
  input  logic [N_IN*CNT_W-1:0]         in_cnt_i,
  output logic [N_IN*(EVT_W+IN_AW)-1:0] in_raddr_o,
  input  logic [N_IN*STUB_W-1:0]        in_rdata_i,
  output logic                          all_we_o,
  output logic [EVT_W+IDX_W-1:0]        all_waddr_o,
  output logic [STUB_W-1:0]             all_wdata_o,
  output logic [N_VM-1:0]               vm_we_o,
  output logic [EVT_W+VM_AW-1:0]        vm_waddr_o,
  output logic [ENT_W-1:0]              vm_wdata_o,
  output logic [IDX_W:0]                drop_cnt_o
);
  logic              iss_vld;
  logic [SEL_W-1:0]  iss_sel;
  logic [IDX_W-1:0]  iss_idx;
  logic [EVT_W-1:0]  iss_evt;
  logic [STUB_W-1:0] stub;
  logic [BIN_W-1:0]  bin;
  logic [ENT_W-1:0]  entry;

  vmr_reader #(
    .N_IN(N_IN), .IN_AW(IN_AW), .EVT_W(EVT_W), .IDX_W(IDX_W), .BUDGET(BUDGET)
  ) u_reader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .evt_i(evt_i),
    .cnt_i(in_cnt_i), .raddr_o(in_raddr_o),
    .iss_vld_o(iss_vld), .iss_sel_o(iss_sel), .iss_idx_o(iss_idx), .iss_evt_o(iss_evt)
  );

  always_comb begin
    stub = '0;
    for (int i = 0; i < N_IN; i++)
      if (iss_sel == SEL_W'(i)) stub = in_rdata_i[i*STUB_W +: STUB_W];
  end

  vmr_binner #(
    .LAYOUT(LAYOUT), .STUB_W(STUB_W), .IDX_W(IDX_W),
    .PHI_CB(PHI_CB), .Z_CB(Z_CB), .PHI_FB(PHI_FB), .Z_FB(Z_FB)
  ) u_binner (
    .stub_i(stub), .idx_i(iss_idx), .bin_o(bin), .entry_o(entry)
  );

  vmr_bin_writer #(
    .STUB_W(STUB_W), .EVT_W(EVT_W), .IDX_W(IDX_W),
    .BIN_W(BIN_W), .ENT_W(ENT_W), .VM_AW(VM_AW)
  ) u_writer (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vld_i(iss_vld),
    .evt_i(iss_evt), .idx_i(iss_idx), .stub_i(stub), .bin_i(bin), .entry_i(entry),
    .all_we_o(all_we_o), .all_waddr_o(all_waddr_o), .all_wdata_o(all_wdata_o),
    .vm_we_o(vm_we_o), .vm_waddr_o(vm_waddr_o), .vm_wdata_o(vm_wdata_o),
    .drop_cnt_o(drop_cnt_o)
  );

  initial begin
    // R4
    budget_fits_chk: assert (BUDGET <= 2 ** IDX_W);
  end
endmodule

// File: tb/vm_stub_router_tb.sv
`timescale 1ns/1ps
module vm_stub_router_tb;
  localparam int BUDGET = 48;
  localparam int CAP    = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [1:0]  evt;
  logic [17:0] in_cnt;
  always #2 clk = ~clk;

  logic [20:0]  raddr  [2];
  logic [107:0] rdata  [2];
  logic         all_we [2];
  logic [7:0]   all_wa [2];
  logic [35:0]  all_wd [2];
  logic [7:0]   vm_we  [2];
  logic [4:0]   vm_wa  [2];
  logic [10:0]  vm_wd  [2];
  logic [6:0]   drop   [2];

  vm_stub_router u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .evt_i(evt), .in_cnt_i(in_cnt),
    .in_raddr_o(raddr[0]), .in_rdata_i(rdata[0]),
    .all_we_o(all_we[0]), .all_waddr_o(all_wa[0]), .all_wdata_o(all_wd[0]),
    .vm_we_o(vm_we[0]), .vm_waddr_o(vm_wa[0]), .vm_wdata_o(vm_wd[0]), .drop_cnt_o(drop[0]));

  vm_stub_router #(.LAYOUT(vmr_pkg::LAYOUT_OUTER)) u_dut_outer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .evt_i(evt), .in_cnt_i(in_cnt),
    .in_raddr_o(raddr[1]), .in_rdata_i(rdata[1]),
    .all_we_o(all_we[1]), .all_waddr_o(all_wa[1]), .all_wdata_o(all_wd[1]),
    .vm_we_o(vm_we[1]), .vm_waddr_o(vm_wa[1]), .vm_wdata_o(vm_wd[1]), .drop_cnt_o(drop[1]));

  // Behavioural memories
  logic [35:0] in_mem  [3][128];
  logic [35:0] all_mem [2][256];
  logic [10:0] vm_mem  [2][8][32];
  int          all_cnt [2];
  int          vm_cnt  [2][8];

  always @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < 3; i++) rdata[d][i*36 +: 36] <= in_mem[i][raddr[d][i*7 +: 7]];
      if (all_we[d]) begin
        all_mem[d][all_wa[d]] = all_wd[d];
        all_cnt[d]++;
      end
      for (int b = 0; b < 8; b++)
        if (vm_we[d][b]) begin
          vm_mem[d][b][vm_wa[d]] = vm_wd[d];
          vm_cnt[d][b]++;
        end
    end
  end

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  int cyc = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  function automatic logic [35:0] gen_stub(int v, int i, int p, bit m);
    logic [63:0] h;
    logic [35:0] s;
    h = 64'(v * 1000 + i * 100 + p + 1) * 64'h9E3779B97F4A7C15;
    h = h ^ (h >> 29);
    s = h[35:0];
    if (m) begin
      s[13:12] = 2'b00;
      s[25]    = 1'b0;
      s[21]    = 1'b0;
    end
    return s;
  endfunction

  function automatic int bin_of(logic [35:0] s, int d);
    return (d == 0) ? int'({s[25], s[13:12]}) : int'({s[21], s[13:12]});
  endfunction

  function automatic logic [10:0] entry_of(logic [35:0] s, int k, int d);
    logic [1:0] zf;
    zf = (d == 0) ? s[24:23] : s[20:19];
    return {6'(k), zf, s[11:9]};
  endfunction

  logic [35:0] exp_stub [BUDGET];
  int n_exp;

  // R2 R3: round-robin order with skipping, stop on exhaustion or budget
  task automatic build_exp(int v, int c0, int c1, int c2, bit m);
    int ptr[3];
    int cnt[3];
    int rr;
    bit found;
    cnt[0] = c0; cnt[1] = c1; cnt[2] = c2;
    ptr[0] = 0;  ptr[1] = 0;  ptr[2] = 0;
    rr = 0; n_exp = 0;
    while (n_exp < BUDGET) begin
      found = 1'b0;
      for (int k = 0; k < 3; k++) begin
        int j;
        j = (rr + k) % 3;
        if (!found && ptr[j] < cnt[j]) begin
          found = 1'b1;
          exp_stub[n_exp] = gen_stub(v, j, ptr[j], m);
          ptr[j]++;
          rr = (j + 1) % 3;
          n_exp++;
        end
      end
      if (!found) break;
    end
  endtask

  task automatic check_dut(int d, int e);
    int ecnt[8];
    logic [10:0] eent [8][CAP];
    int edrop;
    string rb;
    rb = (d == 0) ? "R5" : "R6";
    edrop = 0;
    for (int b = 0; b < 8; b++) ecnt[b] = 0;
    chk(all_cnt[d] == n_exp, "R3", "full-stub write count", all_cnt[d], n_exp);
    for (int k = 0; k < n_exp; k++) begin
      int b;
      chk(all_mem[d][{2'(e), 6'(k)}] == exp_stub[k], "R4", "full-stub data",
          all_mem[d][{2'(e), 6'(k)}], exp_stub[k]);
      b = bin_of(exp_stub[k], d);
      if (ecnt[b] < CAP) begin
        eent[b][ecnt[b]] = entry_of(exp_stub[k], k, d);
        ecnt[b]++;
      end else edrop++;
    end
    for (int b = 0; b < 8; b++) begin
      chk(vm_cnt[d][b] == ecnt[b], rb, "bin write count", vm_cnt[d][b], ecnt[b]);
      for (int s = 0; s < ecnt[b]; s++)
        chk(vm_mem[d][b][{2'(e), 3'(s)}] == eent[b][s], "R7", "bin entry",
            vm_mem[d][b][{2'(e), 3'(s)}], eent[b][s]);
    end
    chk(drop[d] == 7'(edrop), "R8", "drop count", drop[d], edrop);
  endtask

  task automatic run_vec(int v, int c0, int c1, int c2, int e, bit m);
    for (int i = 0; i < 3; i++)
      for (int p = 0; p < 32; p++) in_mem[i][{2'(e), 5'(p)}] = gen_stub(v, i, p, m);
    for (int d = 0; d < 2; d++) begin
      all_cnt[d] = 0;
      for (int a = 0; a < 64; a++) all_mem[d][{2'(e), 6'(a)}] = '1;
      for (int b = 0; b < 8; b++) begin
        vm_cnt[d][b] = 0;
        for (int s = 0; s < 8; s++) vm_mem[d][b][{2'(e), 3'(s)}] = '1;
      end
    end
    build_exp(v, c0, c1, c2, m);
    @(negedge clk);
    in_cnt = {6'(c2), 6'(c1), 6'(c0)};
    evt    = 2'(e);
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(all_we[0] == 1'b0, "R1", "no write one cycle after start", all_we[0], 0);
    @(negedge clk);
    chk(all_we[0] == (n_exp > 0), "R1", "first write two cycles after start",
        all_we[0], (n_exp > 0));
    repeat (BUDGET + 8) @(negedge clk);
    check_dut(0, e);
    check_dut(1, e);
  endtask

  // {mode, evt[1:0], c2[5:0], c1[5:0], c0[5:0]}
  localparam logic [20:0] VEC [7] = '{
    {1'b0, 2'd0, 6'd3,  6'd3,  6'd3 },
    {1'b0, 2'd1, 6'd2,  6'd0,  6'd5 },
    {1'b0, 2'd2, 6'd0,  6'd0,  6'd0 },
    {1'b0, 2'd3, 6'd20, 6'd20, 6'd20},
    {1'b1, 2'd0, 6'd3,  6'd3,  6'd4 },
    {1'b0, 2'd1, 6'd0,  6'd32, 6'd1 },
    {1'b0, 2'd2, 6'd7,  6'd0,  6'd0 }
  };

  initial begin
    rst_n  = 1'b0;
    start  = 1'b0;
    evt    = '0;
    in_cnt = '0;
    repeat (3) @(negedge clk);
    // R9: outputs idle while in reset
    chk(all_we[0] == 1'b0 && vm_we[0] == '0, "R9", "writes in reset", all_we[0], 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(all_we[0] == 1'b0 && all_we[1] == 1'b0, "R9", "full-stub write after reset",
        all_we[0], 0);
    chk(vm_we[0] == '0 && vm_we[1] == '0, "R9", "bin write after reset", vm_we[0], 0);
    chk(drop[0] == '0, "R9", "drop count after reset", drop[0], 0);
    for (int v = 0; v < 7; v++)
      run_vec(v, int'(VEC[v][5:0]), int'(VEC[v][11:6]), int'(VEC[v][17:12]),
              int'(VEC[v][19:18]), VEC[v][20]);
    // R8: a new event clears the drop count and bin fill (vector 4 dropped stubs)
    run_vec(7, 1, 0, 0, 0, 1'b1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule